// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block cleans up to four 8-bit ports of slow digital inputs before the rest of the chip sees them. Each line is first brought into the clock domain through a two-stage synchronizer. A line can then either pass straight through or go through a stability filter. The filter only lets a new level through after that level has stayed unchanged for a programmed time. Short pulses and contact bounce are removed.

All lines share one time setting. It is a 20-bit count of 200 ns periods, and a prescaler derives those periods from the system clock. Each line has its own filter-enable bit and its own stability counter, so lines settle independently while obeying the same interval. Configuration arrives over a simple write strobe with address and data. Software converts a time in nanoseconds into a count by rounding to the nearest 200 ns step before writing it.

Top module: `glitch_filter`

## Requirements
- R1: An internal time base pulses for exactly one clock cycle once every CLK_HZ x 200 ns cycles (25 cycles at 125 MHz), never two cycles in a row.
- R2: A write to address 0x08 loads the shared interval from cfg_wdata[19:0]. Any written value above 0xFFFFF is stored as 0xFFFFF.
- R3: A write to address 0x44 + 0x10*p, for p from 0 to 3, loads the enable byte of port p from cfg_wdata[7:0]. Bit k enables filtering of line k of that port, which is din/dout bit 8*p+k. Enables of other ports are unchanged, and writes to any other address (for example 0x45) change no enable.
- R4: While rst is high every output is 0. After reset every enable bit is 0 and the interval is 0, so all lines pass through.
- R5: A line whose enable bit is 0, or any line while the interval is 0, drives dout from its input three clock edges after the input changes (two synchronizer stages plus the output register).
- R6: A filtered line takes a new input level only after the synchronized input has differed from the output for `interval` time-base pulses. It does not change earlier than that.
- R7: A filtered line's counter clears whenever the synchronized input equals the output. A pulse shorter than the interval never reaches dout, and two short pulses separated by a return to the old level do not add up.
- R8: Any write to the interval address clears every line's counter, so a settling line starts its count again.
- R9: A filtered line changes dout only in a cycle following a time-base pulse, and every change of dout takes the synchronized input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| din | input | 32 | Raw input lines, bit 8*p+k is line k of port p |
| dout | output | 32 | Filtered or passed-through lines, registered |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. The time base never pulses twice in a row. Bypassed lines copy the synchronized input one cycle later. Filtered lines move only right after a time-base pulse. Every output change takes the synchronized value, and oversized interval writes saturate. Other properties only show over many cycles, and only the bench scenarios can demonstrate them. These are the minimum and maximum settling windows, the rejection of single and split glitches, the restart of counters after an interval write, per-line enable selection, and address decoding.

// File: rtl/glf_pkg.sv
package glf_pkg;
  localparam int unsigned IVL_ADDR    = 32'h08;
  localparam int unsigned PORT_BASE   = 32'h40;
  localparam int unsigned PORT_STRIDE = 32'h10;
  localparam int unsigned EN_OFFSET   = 32'h04;
  localparam int unsigned NS_PER_S    = 32'd1_000_000_000;
endpackage

// File: rtl/glf_tick_gen.sv
module glf_tick_gen #(
  parameter int unsigned DIV = 25
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/glf_cfg_regs.sv
module glf_cfg_regs
  import glf_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LPP       = 8,
  parameter int unsigned IVL_W     = 20,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [IVL_W-1:0]         ival,
  output logic                     ival_wr,
  output logic [NUM_PORTS*LPP-1:0] en
);
  localparam logic [DATA_W-1:0] IVL_MAX  = DATA_W'((64'd1 << IVL_W) - 1);
  localparam logic [ADDR_W-1:0] IVL_A    = ADDR_W'(IVL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ival    <= '0;
      ival_wr <= 1'b0;
    end else begin
      ival_wr <= we && (addr == IVL_A);
      if (we && (addr == IVL_A)) begin
        if (wdata > IVL_MAX) ival <= IVL_MAX[IVL_W-1:0];
        else                 ival <= wdata[IVL_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_en
    localparam logic [ADDR_W-1:0] EN_A =
      ADDR_W'(PORT_BASE + p * PORT_STRIDE + EN_OFFSET);
    always_ff @(posedge clk) begin
      if (rst)                          en[p*LPP +: LPP] <= '0;
      else if (we && (addr == EN_A))    en[p*LPP +: LPP] <= wdata[LPP-1:0];
    end
  end
endmodule

// File: rtl/glf_line_filter.sv
module glf_line_filter #(
  parameter int unsigned IVL_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             enable,
  input  logic [IVL_W-1:0] ival,
  input  logic             tick,
  input  logic             restart,
  output logic             out
);
  logic [IVL_W-1:0] cnt;
  logic [IVL_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      out <= 1'b0;
    end else if (!enable || (ival == '0)) begin
      cnt <= '0;
      out <= sync_in;
    end else if (restart || (sync_in == out)) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt_nxt >= {1'b0, ival}) begin
        cnt <= '0;
        out <= sync_in;
      end else begin
        cnt <= cnt_nxt[IVL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import glf_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned TICK_NS   = 200,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LPP       = 8,
  parameter int unsigned IVL_W     = 20,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic [NUM_PORTS*LPP-1:0] din,
  output logic [NUM_PORTS*LPP-1:0] dout
);
  localparam int unsigned NL      = NUM_PORTS * LPP;
  localparam int unsigned TICK_HZ = NS_PER_S / TICK_NS;
  localparam int unsigned DIV     = CLK_HZ / TICK_HZ;

  logic [NL-1:0]    meta_q, sync_q;
  logic [IVL_W-1:0] ival;
  logic             ival_wr;
  logic [NL-1:0]    en;
  logic             tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  glf_tick_gen #(.DIV(DIV)) i_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  glf_cfg_regs #(
    .NUM_PORTS(NUM_PORTS), .LPP(LPP), .IVL_W(IVL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .ival   (ival),
    .ival_wr(ival_wr),
    .en     (en)
  );

  for (genvar i = 0; i < NL; i++) begin : g_line
    glf_line_filter #(.IVL_W(IVL_W)) i_flt (
      .clk    (clk),
      .rst    (rst),
      .sync_in(sync_q[i]),
      .enable (en[i]),
      .ival   (ival),
      .tick   (tick),
      .restart(ival_wr),
      .out    (dout[i])
    );
  end
endmodule

// File: rtl/glf_checker.sv
module glf_checker #(
  parameter int unsigned NL     = 32,
  parameter int unsigned IVL_W  = 20,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [NL-1:0]     dout,
  input logic [NL-1:0]     sync_q,
  input logic [NL-1:0]     en,
  input logic [IVL_W-1:0]  ival,
  input logic              tick
);
  localparam logic [DATA_W-1:0] MAXV = DATA_W'((64'd1 << IVL_W) - 1);
  logic [NL-1:0] byp;
  assign byp = (ival == '0) ? '1 : ~en;

  // R1: time base is a single-cycle pulse
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2: oversized interval saturates
  p_saturate_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == ADDR_W'(8'h08) && cfg_wdata > MAXV)
      |=> (ival == MAXV[IVL_W-1:0]));

  // R5: bypassed lines copy the synchronized input
  p_bypass_follow_r5: assert property (@(posedge clk) disable iff (rst)
    ((dout ^ $past(sync_q)) & $past(byp)) == '0);

  // R9: filtered lines move only after a tick
  p_filt_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (((dout ^ $past(dout)) & ~$past(byp)) != '0) |-> $past(tick));

  // R9: every change takes the synchronized value
  p_take_sync_r9: assert property (@(posedge clk) disable iff (rst)
    ((dout ^ $past(dout)) & (dout ^ $past(sync_q))) == '0);
endmodule

bind glitch_filter glf_checker #(
  .NL(NUM_PORTS*LPP), .IVL_W(IVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_glf_checker (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .dout     (dout),
  .sync_q   (sync_q),
  .en       (en),
  .ival     (ival),
  .tick     (tick)
);

// File: tb/test_glitch_filter.sv
module test_glitch_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] model = '0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  glitch_filter i_glitch_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .din(din), .dout(dout)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic expect_out(input string tag);
    item_t it;
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  function automatic void set_byte(input int p, input logic [7:0] v);
    model[p*8 +: 8] = v;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (dout !== it.exp) begin
          n_errors++;
          $display("FAIL %s: dout=%h expected=%h", it.tag, dout, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    // R4: outputs held at zero in reset
    din = 32'hA5A5_A5A5;
    step(5);
    model = '0;
    expect_out("R4 reset outputs zero");
    step(1);
    rst = 1'b0;
    step(4);
    model = din;
    expect_out("R4 pass-through after reset");

    // R5: raw pass-through with new pattern
    din = 32'h3C3C_0F0F;
    step(4);
    model = din;
    expect_out("R5 raw follow");

    // R6: filtered settling window on port 0, port 3 stays raw
    cfg_write(8'h08, 32'd4);
    cfg_write(8'h44, 32'h0000_00FF);
    step(2);
    din[7:0] = 8'hF0;
    din[31:24] = 8'h11;
    step(60);
    set_byte(3, 8'h11);
    expect_out("R6 no early change, R3 port3 raw");
    step(50);
    set_byte(0, 8'hF0);
    expect_out("R6 settled after interval");

    // R7: single short glitch rejected
    din[7:0] = 8'h00;
    step(40);
    din[7:0] = 8'hF0;
    step(150);
    expect_out("R7 short glitch rejected");

    // R7: two short pulses do not accumulate
    din[7:0] = 8'h00;
    step(60);
    din[7:0] = 8'hF0;
    step(10);
    din[7:0] = 8'h00;
    step(60);
    din[7:0] = 8'hF0;
    step(150);
    expect_out("R7 split glitch rejected");

    // R8: interval write restarts counting
    din[7:0] = 8'h00;
    step(65);
    cfg_write(8'h08, 32'd4);
    step(70);
    expect_out("R8 count restarted");
    step(40);
    set_byte(0, 8'h00);
    expect_out("R8 settled after restart");

    // R3: per-line enables on port 1, port 2 raw
    cfg_write(8'h54, 32'h0000_000F);
    step(2);
    din[15:8]  = 8'hF0;
    din[23:16] = 8'h5A;
    step(5);
    set_byte(1, 8'hFF);
    set_byte(2, 8'h5A);
    expect_out("R3 upper nibble raw, lower held");
    step(110);
    set_byte(1, 8'hF0);
    expect_out("R3 lower nibble settled");

    // R3: write to a non-enable address ignored
    cfg_write(8'h45, 32'h0000_0000);
    step(2);
    din[7:0] = 8'hFF;
    step(5);
    expect_out("R3 stray address ignored");
    step(110);
    set_byte(0, 8'hFF);
    expect_out("R3 port0 still filtered");

    // R5: interval zero bypasses enabled lines
    cfg_write(8'h08, 32'd0);
    step(1);
    din[7:0] = 8'h81;
    step(4);
    set_byte(0, 8'h81);
    expect_out("R5 interval zero bypass");

    // R2: oversized value saturates instead of wrapping to zero
    cfg_write(8'h08, 32'h0010_0000);
    step(1);
    din[7:0] = 8'h7E;
    step(60);
    expect_out("R2 saturated interval holds");

    // R2: normal value loads and restarts
    cfg_write(8'h08, 32'd2);
    step(80);
    set_byte(0, 8'h7E);
    expect_out("R2 interval of two settles");

    // R1: tick period lower bound with interval two
    din[7:0] = 8'h24;
    step(25);
    expect_out("R1 no change before two tick periods");
    step(40);
    set_byte(0, 8'h24);
    expect_out("R1 change within three tick periods");

    // R1: interval one settles within one period
    cfg_write(8'h08, 32'd1);
    step(1);
    din[7:0] = 8'h99;
    step(30);
    set_byte(0, 8'h99);
    expect_out("R1 interval of one");

    step(3);
    done = 1'b1;
    summary();
  end
endmodule